// File: doc/BRIEF.md
# Segmented DMA Transfer Controller

This block sits between an SPI slave protocol engine and local logic. It keeps one slave-side transfer in each direction. In the read direction, local logic fills an internal buffer, then loads a transfer length. The master drains that transfer one byte per request, across as many bus transactions of whatever size it likes. The read position is held between transactions, so each new segment picks up where the last one stopped. Requests beyond the loaded length return filler. When the master sends the read termination command, local logic sees a one-cycle done pulse and the number of real bytes consumed, and the channel becomes free to load again.

The write direction mirrors this. Local logic arms the channel, and the master streams bytes into an internal buffer in several segments. The write termination command reports how many bytes were stored. Bytes beyond the buffer capacity are discarded and raise an overflow flag. Both buffers are plain single-write, single-read memories with a registered read port, so they can map onto block RAM.

Top module: `seg_dma_ctrl`

## Requirements
- R1: After reset, both channels are idle, with `rd_active`, `wr_armed`, `rd_done`, `wr_done`, `spi_rd_valid`, `wr_overflow` and the busy flags all low, and `spi_rd_data` at 0x00.
- R2: A read load while the read channel is idle is accepted. `rd_active` rises the next cycle and the read offset restarts at 0. Each cycle with `spi_rd_req` high yields `spi_rd_valid` one cycle later, carrying the buffer byte at the current offset.
- R3: The read offset is kept across idle gaps between segments. A new segment continues with the byte after the last one delivered.
- R4: A read request when the offset has reached the loaded length returns 0x00 and does not advance the offset.
- R5: A read request while no transfer is active returns `spi_rd_valid` with data 0x00.
- R6: Command code 0x08 while a read transfer is active gives a one-cycle `rd_done` pulse on the next cycle. `rd_done_count` then equals the number of real bytes delivered, and `rd_active` drops.
- R7: A read load while a read transfer is active is rejected with a one-cycle `rd_load_busy` pulse. The active transfer keeps its length and offset.
- R8: A write arm while the write channel is idle is accepted and restarts the byte count at 0. Each `spi_wr_valid` byte is stored at the next address. A drain read returns the stored byte one cycle after `drain_re`.
- R9: Command code 0x07 while the write channel is armed gives a one-cycle `wr_done` pulse on the next cycle, with `wr_done_count` equal to the number of bytes stored, and disarms the channel.
- R10: While armed, a write byte that arrives with the buffer full is dropped and sets `wr_overflow`. The flag stays set until the next accepted arm clears it, and stored contents are unchanged.
- R11: A write arm while the write channel is armed is rejected with a one-cycle `wr_arm_busy` pulse.
- R12: Other command codes, and a termination command for a channel that is not active, produce no done pulse and change no channel state.
- R13: A read load length larger than the buffer depth is clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cmd_valid | input | 1 | Command byte strobe from the SPI engine |
| spi_cmd | input | 8 | Command code |
| spi_rd_req | input | 1 | Request for the next DMA-read byte |
| spi_rd_valid | output | 1 | Read byte valid, one cycle after the request |
| spi_rd_data | output | 8 | Read byte, or 0x00 as filler |
| spi_wr_valid | input | 1 | DMA-write byte strobe |
| spi_wr_data | input | 8 | DMA-write byte |
| rd_load | input | 1 | Load request for a read transfer |
| rd_load_len | input | LEN_W | Read transfer length in bytes |
| rd_load_busy | output | 1 | Pulse: read load rejected |
| rd_done | output | 1 | Pulse: read transfer terminated |
| rd_done_count | output | CNT_W | Real bytes delivered in the finished read transfer |
| rd_active | output | 1 | Read transfer loaded and not yet terminated |
| fill_we | input | 1 | Local write into the read buffer |
| fill_addr | input | AW | Read buffer address |
| fill_data | input | 8 | Read buffer data |
| wr_arm | input | 1 | Arm request for a write transfer |
| wr_arm_busy | output | 1 | Pulse: write arm rejected |
| wr_done | output | 1 | Pulse: write transfer terminated |
| wr_done_count | output | CNT_W | Bytes stored in the finished write transfer |
| wr_overflow | output | 1 | Bytes were dropped because the write buffer was full |
| wr_armed | output | 1 | Write channel armed and not yet terminated |
| drain_re | input | 1 | Local read of the write buffer |
| drain_addr | input | AW | Write buffer address |
| drain_data | output | 8 | Write buffer data, one cycle after `drain_re` |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. A read byte follows its request by one edge, and the done pulses, the counts, the busy pulses and `rd_active` follow their command or load by one edge. The stored-write effects and the drain data also follow by one edge. The bench drives on the falling edge. A scoreboard queue records one expected byte for every request. A monitor on the falling edge pops and compares an entry each time `spi_rd_valid` is high, so a byte that comes early, late, extra or missing is reported. The other results are sampled on the falling edge straight after the causing edge, and the one-cycle pulses are checked again one cycle later to confirm they have dropped.

// File: rtl/seg_dma_pkg.sv
package seg_dma_pkg;
  localparam logic [7:0] CMD_WR_END = 8'h07;
  localparam logic [7:0] CMD_RD_END = 8'h08;
  localparam logic [7:0] FILL_BYTE  = 8'h00;
endpackage

// File: rtl/sdma_ram.sv
module sdma_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sdma_rd_chan.sv
module sdma_rd_chan #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             req,
  input  logic             term,
  output logic             ram_re,
  output logic [AW-1:0]    ram_raddr,
  output logic             active,
  output logic             busy,
  output logic             done,
  output logic [CW-1:0]    count,
  output logic             valid,
  output logic             pad
);
  logic [CW-1:0] off, len, len_in;
  logic          hit;

  assign len_in    = (ld_len > LEN_W'(DEPTH)) ? CW'(DEPTH) : ld_len[CW-1:0];
  assign hit       = req && active && (off < len);
  assign ram_re    = hit;
  assign ram_raddr = off[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      off    <= '0;
      len    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      count  <= '0;
      valid  <= 1'b0;
      pad    <= 1'b1;
    end else begin
      busy  <= ld && active;
      done  <= 1'b0;
      valid <= req;
      pad   <= !hit;
      if (term && active) begin
        done   <= 1'b1;
        count  <= off + CW'(hit);
        active <= 1'b0;
      end
      if (ld && !active) begin
        active <= 1'b1;
        len    <= len_in;
        off    <= '0;
      end else if (hit) begin
        off <= off + 1'b1;
      end
    end
  end

  AST_RD_OFF_BOUND: assert property (@(posedge clk) disable iff (rst)
    off <= len);  // R4
  AST_RD_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_RD_BUSY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ld && active && !term) |=> (busy && active && $stable(len)));  // R7
endmodule

// File: rtl/sdma_wr_chan.sv
module sdma_wr_chan #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          wvalid,
  input  logic          term,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic          armed,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [CW-1:0] cnt;
  logic          store, drop;

  assign store     = wvalid && armed && (cnt < CW'(DEPTH));
  assign drop      = wvalid && armed && (cnt == CW'(DEPTH));
  assign ram_we    = store;
  assign ram_waddr = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      busy <= ld && armed;
      done <= 1'b0;
      if (term && armed) begin
        done  <= 1'b1;
        count <= cnt + CW'(store);
        armed <= 1'b0;
      end
      if (ld && !armed) begin
        armed <= 1'b1;
        cnt   <= '0;
        ovf   <= 1'b0;
      end else begin
        if (store) cnt <= cnt + 1'b1;
        if (drop)  ovf <= 1'b1;
      end
    end
  end

  AST_WR_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));  // R10
  AST_WR_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ld) |=> ovf);  // R10
  AST_WR_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9
endmodule

// File: rtl/seg_dma_ctrl.sv
module seg_dma_ctrl
  import seg_dma_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_cmd_valid,
  input  logic [7:0]       spi_cmd,
  input  logic             spi_rd_req,
  output logic             spi_rd_valid,
  output logic [7:0]       spi_rd_data,
  input  logic             spi_wr_valid,
  input  logic [7:0]       spi_wr_data,
  input  logic             rd_load,
  input  logic [LEN_W-1:0] rd_load_len,
  output logic             rd_load_busy,
  output logic             rd_done,
  output logic [CNT_W-1:0] rd_done_count,
  output logic             rd_active,
  input  logic             fill_we,
  input  logic [AW-1:0]    fill_addr,
  input  logic [7:0]       fill_data,
  input  logic             wr_arm,
  output logic             wr_arm_busy,
  output logic             wr_done,
  output logic [CNT_W-1:0] wr_done_count,
  output logic             wr_overflow,
  output logic             wr_armed,
  input  logic             drain_re,
  input  logic [AW-1:0]    drain_addr,
  output logic [7:0]       drain_data
);
  logic          term_rd, term_wr;
  logic          rram_re, rd_pad;
  logic [AW-1:0] rram_addr;
  logic [7:0]    rram_q;
  logic          wram_we;
  logic [AW-1:0] wram_addr;

  assign term_rd = spi_cmd_valid && (spi_cmd == CMD_RD_END);
  assign term_wr = spi_cmd_valid && (spi_cmd == CMD_WR_END);

  sdma_rd_chan #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst(rst), .ld(rd_load), .ld_len(rd_load_len),
    .req(spi_rd_req), .term(term_rd), .ram_re(rram_re), .ram_raddr(rram_addr),
    .active(rd_active), .busy(rd_load_busy), .done(rd_done),
    .count(rd_done_count), .valid(spi_rd_valid), .pad(rd_pad)
  );

  sdma_ram #(.DW(8), .DEPTH(DEPTH)) u_rd_buf (
    .clk(clk), .we(fill_we), .waddr(fill_addr), .wdata(fill_data),
    .re(rram_re), .raddr(rram_addr), .rdata(rram_q)
  );

  assign spi_rd_data = rd_pad ? FILL_BYTE : rram_q;

  sdma_wr_chan #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .ld(wr_arm), .wvalid(spi_wr_valid), .term(term_wr),
    .ram_we(wram_we), .ram_waddr(wram_addr), .armed(wr_armed),
    .busy(wr_arm_busy), .done(wr_done), .count(wr_done_count), .ovf(wr_overflow)
  );

  sdma_ram #(.DW(8), .DEPTH(DEPTH)) u_wr_buf (
    .clk(clk), .we(wram_we), .waddr(wram_addr), .wdata(spi_wr_data),
    .re(drain_re), .raddr(drain_addr), .rdata(drain_data)
  );

  AST_RD_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
    (spi_rd_req && !rd_active) |=> (spi_rd_valid && spi_rd_data == 8'h00));  // R5
  AST_CMD_OTHER: assert property (@(posedge clk) disable iff (rst)
    (spi_cmd_valid && spi_cmd != 8'h07 && spi_cmd != 8'h08) |=> (!rd_done && !wr_done));  // R12
endmodule

// File: tb/seg_dma_ctrl_tb.sv
module seg_dma_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int LEN_W = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic spi_cmd_valid = 0, spi_rd_req = 0, spi_wr_valid = 0;
  logic [7:0] spi_cmd = 0, spi_wr_data = 0, fill_data = 0;
  logic rd_load = 0, fill_we = 0, wr_arm = 0, drain_re = 0;
  logic [LEN_W-1:0] rd_load_len = 0;
  logic [AW-1:0] fill_addr = 0, drain_addr = 0;
  logic spi_rd_valid, rd_load_busy, rd_done, rd_active;
  logic wr_arm_busy, wr_done, wr_overflow, wr_armed;
  logic [7:0] spi_rd_data, drain_data;
  logic [CW-1:0] rd_done_count, wr_done_count;

  always #5 clk = ~clk;

  seg_dma_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] ref_rd [DEPTH];
  logic [7:0] exp_q [$];
  int m_off = 0, m_len = 0;
  bit m_active = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && spi_rd_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected read byte", 32'(spi_rd_data), 32'hFFFF);
      else chk("R2/R3/R4/R5 read byte", 32'(spi_rd_data), 32'(exp_q.pop_front()));
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 5 + 17) & 8'hFF);
  endfunction

  task automatic read_seg(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      spi_rd_req = 1'b1;
      if (m_active && m_off < m_len) begin
        exp_q.push_back(ref_rd[m_off]);
        m_off++;
      end else exp_q.push_back(8'h00);
    end
    @(negedge clk);
    spi_rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input int len);
    @(negedge clk);
    rd_load = 1'b1;
    rd_load_len = LEN_W'(len);
    @(negedge clk);
    rd_load = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    spi_cmd_valid = 1'b1;
    spi_cmd = c;
    @(negedge clk);
    spi_cmd_valid = 1'b0;
  endtask

  task automatic write_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      spi_wr_valid = 1'b1;
      spi_wr_data = pat(base + i);
    end
    @(negedge clk);
    spi_wr_valid = 1'b0;
  endtask

  task automatic drain_chk(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    drain_re = 1'b1;
    drain_addr = AW'(a);
    @(negedge clk);
    drain_re = 1'b0;
    chk(tag, 32'(drain_data), 32'(exp));
  endtask

  task automatic arm();
    @(negedge clk);
    wr_arm = 1'b1;
    @(negedge clk);
    wr_arm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_active", 32'(rd_active), 0);
    chk("R1 wr_armed", 32'(wr_armed), 0);
    chk("R1 rd_done", 32'(rd_done), 0);
    chk("R1 wr_done", 32'(wr_done), 0);
    chk("R1 spi_rd_valid", 32'(spi_rd_valid), 0);
    chk("R1 spi_rd_data", 32'(spi_rd_data), 0);
    chk("R1 wr_overflow", 32'(wr_overflow), 0);
    chk("R1 busy flags", 32'({rd_load_busy, wr_arm_busy}), 0);

    // R5: read with nothing loaded
    read_seg(3);

    // fill read buffer from local side
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      fill_we = 1'b1;
      fill_addr = AW'(i);
      fill_data = pat(i);
      ref_rd[i] = pat(i);
    end
    @(negedge clk);
    fill_we = 1'b0;

    // R2: load 60 bytes
    load(60);
    m_active = 1; m_len = 60; m_off = 0;
    chk("R2 rd_active after load", 32'(rd_active), 1);
    chk("R2 no busy on accepted load", 32'(rd_load_busy), 0);

    // R3: segments with gaps
    for (int s = 0; s < 3; s++) begin
      read_seg(8);
      repeat (2) @(negedge clk);
    end

    // R7: rejected load, transfer continues
    load(5);
    chk("R7 rd_load_busy pulse", 32'(rd_load_busy), 1);
    chk("R7 rd_active kept", 32'(rd_active), 1);
    @(negedge clk);
    chk("R7 busy one cycle", 32'(rd_load_busy), 0);

    // R3/R4: remaining segments, last one crosses the end
    for (int s = 0; s < 5; s++) read_seg(8);
    read_seg(4);  // R4 all filler

    // R12: other codes and idle write termination
    send_cmd(8'h55);
    chk("R12 no rd_done on other code", 32'(rd_done), 0);
    chk("R12 rd_active unchanged", 32'(rd_active), 1);
    send_cmd(8'h07);
    chk("R12 no wr_done when not armed", 32'(wr_done), 0);

    // R6: terminate read
    send_cmd(8'h08);
    m_active = 0;
    chk("R6 rd_done pulse", 32'(rd_done), 1);
    chk("R6 rd_done_count", 32'(rd_done_count), 60);
    chk("R6 rd_active cleared", 32'(rd_active), 0);
    @(negedge clk);
    chk("R6 rd_done one cycle", 32'(rd_done), 0);
    send_cmd(8'h08);
    chk("R12 no rd_done when idle", 32'(rd_done), 0);

    // R5: read after termination
    read_seg(2);

    // R6: partial transfer count
    load(10);
    m_active = 1; m_len = 10; m_off = 0;
    read_seg(4);
    send_cmd(8'h08);
    m_active = 0;
    chk("R6 partial count", 32'(rd_done_count), 4);

    // R13: clamp
    load(1000);
    m_active = 1; m_len = DEPTH; m_off = 0;
    read_seg(66);
    send_cmd(8'h08);
    m_active = 0;
    chk("R13 clamped count", 32'(rd_done_count), DEPTH);

    // R8/R9: write channel
    arm();
    chk("R8 wr_armed", 32'(wr_armed), 1);
    write_bytes(5, 100);
    send_cmd(8'h07);
    chk("R9 wr_done pulse", 32'(wr_done), 1);
    chk("R9 wr_done_count", 32'(wr_done_count), 5);
    chk("R9 disarmed", 32'(wr_armed), 0);
    @(negedge clk);
    chk("R9 wr_done one cycle", 32'(wr_done), 0);
    for (int i = 0; i < 5; i++) drain_chk(i, pat(100 + i), "R8 drained byte");

    // R11 / R10
    arm();
    arm();
    chk("R11 wr_arm_busy pulse", 32'(wr_arm_busy), 1);
    chk("R11 still armed", 32'(wr_armed), 1);
    write_bytes(DEPTH, 200);
    chk("R10 no overflow at exactly full", 32'(wr_overflow), 0);
    write_bytes(6, 50);
    chk("R10 overflow set", 32'(wr_overflow), 1);
    drain_chk(0, pat(200), "R10 first byte kept");
    drain_chk(DEPTH - 1, pat(200 + DEPTH - 1), "R10 last byte kept");
    send_cmd(8'h07);
    chk("R10 count capped", 32'(wr_done_count), DEPTH);
    chk("R10 overflow held after done", 32'(wr_overflow), 1);
    arm();
    chk("R10 overflow cleared by arm", 32'(wr_overflow), 0);
    send_cmd(8'h07);
    chk("R9 empty transfer count", 32'(wr_done_count), 0);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule